// File: doc/BRIEF.md
# SEC-DED 72/64 Checker and Corrector

This block checks one 72-bit code word per cycle. The word is a 64-bit data word and its 8-bit check byte. The block recomputes the check byte from the data using a fixed parity matrix. Every matrix row is a single 64-bit pattern rotated left by whole bytes. The recomputed byte is XORed with the received byte to form a syndrome.

The syndrome is decoded into one of three results:
- **Clean:** the syndrome is zero.
- **Corrected:** a single bit was flipped, either in the data or in the check byte, and it is flipped back.
- **Uncorrectable:** any other syndrome, including every double-bit error.

The outputs are the corrected data, the corrected check byte, a status code and the index of the failing bit. They are registered, so each result appears one clock after its input word. A sticky flag records whether any word of the current transfer was uncorrectable. The first word of a new transfer restarts the flag.

Bit positions count from the data MSB downward. Position 0 is data bit 63 and position 63 is data bit 0. Positions 64 to 71 name check-byte bits 0 to 7.

Top module: `secded_checker`

## Requirements
- R1: Check bit i (0..7) is the XOR reduction of the data ANDed with row i. Row 0 is 64'h0000e8423c0f99ff. Row i+1 is row i rotated left by 8 bits, so row 7 is 64'hff0000e8423c0f99. A word whose check byte equals this value is reported clean.
- R2: A zero syndrome gives status 0 (clean). Data and check byte pass through unchanged, and the index reads 127.
- R3: A syndrome equal to 2^i (i = 0..7) is a check-byte error. The block flips check bit i, leaves the data unchanged, gives status 1 (corrected) and index 64+i.
- R4: A syndrome equal to the matrix column of data position p is a data error at p. The block flips data bit 63−p, gives status 1 and index p. Sample cases: syndrome 0x07 gives p=47, 0x0B gives 37, 0x0D gives 35, 0x0E gives 39, 0x13 gives 48, 0x15 gives 30 and 0x16 gives 29.
- R5: Every other syndrome gives status 2 (uncorrectable). Data and check byte pass through unmodified, and the index reads 127. Any two flipped bits of the 72 give status 2.
- R6: Results are registered. Outputs change one clock edge after a word is presented with in_valid high, and out_valid is in_valid delayed by one cycle. While in_valid is low, all result outputs hold their values.
- R7: out_sticky is set by an uncorrectable word and stays set for later words. A word presented with in_first high restarts the flag from that word's own result.
- R8: After reset, out_valid, out_sticky, out_data, out_check and out_status are 0, and out_pos is 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_first | input | 1 | Word opens a new transfer (restarts sticky flag) |
| in_data | input | 64 | Received data word |
| in_check | input | 8 | Received check byte |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Corrected data (passed through when uncorrectable) |
| out_check | output | 8 | Corrected check byte |
| out_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| out_pos | output | 7 | Failing bit index, 127 when none |
| out_sticky | output | 1 | Uncorrectable seen in current transfer |

## Verification
All results, including the sticky flag, are due exactly one clock edge after the word is presented. The bench drives each word on a falling edge and samples every output one time unit after the next rising edge. Hold behaviour is checked the same way after a cycle with in_valid low. Expected data, check byte, status and index come from a bit-serial model of the matrix in the bench. That model is exercised by injecting each of the 72 single-bit flips and a sweep of double-bit flips.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int POS_W  = 7;
  localparam int ROT    = DATA_W / CHK_W;
  localparam logic [DATA_W-1:0] ROW_SEED = 64'h0000e8423c0f99ff;
  localparam logic [POS_W-1:0]  POS_NONE = '1;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_FATAL = 2'd2
  } status_e;

  // Matrix row for check bit idx: seed rotated left by ROT*idx bits.
  function automatic logic [DATA_W-1:0] parity_row(input int idx);
    logic [DATA_W-1:0] r;
    r = ROW_SEED;
    for (int k = 0; k < idx; k++) r = {r[DATA_W-ROT-1:0], r[DATA_W-1:DATA_W-ROT]};
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] calc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int i = 0; i < CHK_W; i++) c[i] = ^(d & parity_row(i));
    return c;
  endfunction

  // Syndrome produced by a flip at position p (data bit DATA_W-1-p).
  function automatic logic [CHK_W-1:0] column(input int p);
    logic [CHK_W-1:0] c;
    logic [DATA_W-1:0] r;
    for (int i = 0; i < CHK_W; i++) begin
      r = parity_row(i);
      c[i] = r[DATA_W-1-p];
    end
    return c;
  endfunction
endpackage

// File: rtl/secded_check_gen.sv
module secded_check_gen
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);
  always_comb check = calc_check(data);
endmodule

// File: rtl/secded_syn_decode.sv
module secded_syn_decode
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  parameter int PW = POS_W
) (
  input  logic [CW-1:0] syn,
  output logic          fix_data,
  output logic          fix_chk,
  output logic          fatal,
  output logic [PW-1:0] pos
);
  logic          hit_data;
  logic [PW-1:0] data_pos;
  logic          hit_chk;
  logic [PW-1:0] chk_pos;

  // Data-position decode: one comparator per matrix column.
  always_comb begin
    hit_data = 1'b0;
    data_pos = '0;
    for (int p = 0; p < DW; p++) begin
      if (column(p) == syn) begin
        hit_data = 1'b1;
        data_pos = PW'(p);
      end
    end
  end

  // Check-byte decode: syndrome with a single bit set.
  always_comb begin
    hit_chk = 1'b0;
    chk_pos = '0;
    for (int i = 0; i < CW; i++) begin
      if (syn == CW'(1 << i)) begin
        hit_chk = 1'b1;
        chk_pos = PW'(DW + i);
      end
    end
  end

  always_comb begin
    fix_data = hit_data;
    fix_chk  = hit_chk;
    fatal    = (syn != '0) && !hit_data && !hit_chk;
    pos      = hit_data ? data_pos : (hit_chk ? chk_pos : POS_NONE);
  end
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  parameter int PW = POS_W
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] check,
  input  logic          fix_data,
  input  logic          fix_chk,
  input  logic [PW-1:0] pos,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] check_o
);
  localparam int DIW = $clog2(DW);
  localparam int CIW = $clog2(CW);

  logic [DIW-1:0] data_bit;
  logic [CIW-1:0] chk_bit;

  always_comb begin
    data_bit = DIW'(DW - 1) - pos[DIW-1:0];
    chk_bit  = pos[CIW-1:0];
    data_o   = data;
    check_o  = check;
    if (fix_data) data_o[data_bit] = ~data[data_bit];
    if (fix_chk)  check_o[chk_bit] = ~check[chk_bit];
  end
endmodule

// File: rtl/secded_checker.sv
module secded_checker
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_check,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_check,
  output logic [1:0]    out_status,
  output logic [PW-1:0] out_pos,
  output logic          out_sticky
);
  // Named internal events, observed by the bound checker.
  logic [CW-1:0] recomputed;
  logic [CW-1:0] syndrome;
  logic          dec_fix_data;
  logic          dec_fix_chk;
  logic          dec_fatal;
  logic [PW-1:0] dec_pos;
  logic [DW-1:0] fixed_data;
  logic [CW-1:0] fixed_check;
  status_e       next_status;

  secded_check_gen #(.DW(DW), .CW(CW)) u_gen (
    .data  (in_data),
    .check (recomputed)
  );

  assign syndrome = recomputed ^ in_check;

  secded_syn_decode #(.DW(DW), .CW(CW), .PW(PW)) u_dec (
    .syn      (syndrome),
    .fix_data (dec_fix_data),
    .fix_chk  (dec_fix_chk),
    .fatal    (dec_fatal),
    .pos      (dec_pos)
  );

  secded_fix #(.DW(DW), .CW(CW), .PW(PW)) u_fix (
    .data     (in_data),
    .check    (in_check),
    .fix_data (dec_fix_data),
    .fix_chk  (dec_fix_chk),
    .pos      (dec_pos),
    .data_o   (fixed_data),
    .check_o  (fixed_check)
  );

  always_comb begin
    if (dec_fatal)                        next_status = ST_FATAL;
    else if (dec_fix_data || dec_fix_chk) next_status = ST_FIXED;
    else                                  next_status = ST_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_check  <= '0;
      out_status <= ST_CLEAN;
      out_pos    <= POS_NONE;
      out_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data   <= fixed_data;
        out_check  <= fixed_check;
        out_status <= next_status;
        out_pos    <= dec_pos;
        out_sticky <= (in_first ? 1'b0 : out_sticky) | dec_fatal;
      end
    end
  end
endmodule

// File: rtl/secded_checker_sva.sv
module secded_checker_sva #(
  parameter int DW = 64,
  parameter int CW = 8,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic [CW-1:0] in_check,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_check,
  input logic [1:0]    out_status,
  input logic [PW-1:0] out_pos,
  input logic          out_sticky,
  input logic [CW-1:0] syndrome,
  input logic          dec_fatal
);
  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_status) && $stable(out_pos)));

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && syndrome == '0) |=>
      (out_status == 2'd0 && out_data == $past(in_data) && out_check == $past(in_check)));

  // R5
  fatal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_fatal) |=>
      (out_status == 2'd2 && out_data == $past(in_data) && out_pos == '1));

  // R3
  fixed_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_status != 2'd1 ||
      $countones({out_data, out_check} ^ $past({in_data, in_check})) == 1));

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_fatal) |=> out_sticky);

  // R5
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_status != 2'd3);
endmodule

bind secded_checker secded_checker_sva #(.DW(DW), .CW(CW), .PW(PW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_check   (in_check),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_check  (out_check),
  .out_status (out_status),
  .out_pos    (out_pos),
  .out_sticky (out_sticky),
  .syndrome   (syndrome),
  .dec_fatal  (dec_fatal)
);

// File: tb/test_secded_checker.sv
module test_secded_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // Vector: {data, flip mask {data,check}, expected status, expected index}
  localparam logic [144:0] VEC [NV] = '{
    {64'h0123456789abcdef, 72'h0,                               2'd0, 7'd127},
    {64'h0123456789abcdef, {64'h8000000000000000, 8'h00},       2'd1, 7'd0},
    {64'hffffffffffffffff, {64'h0000000000000001, 8'h00},       2'd1, 7'd63},
    {64'hdeadbeefcafef00d, {64'h0, 8'h01},                      2'd1, 7'd64},
    {64'hdeadbeefcafef00d, {64'h0, 8'h80},                      2'd1, 7'd71},
    {64'h0000000000000000, {64'h0000000000000003, 8'h00},       2'd2, 7'd127},
    {64'h5555aaaa3333cccc, {64'h0, 8'h03},                      2'd2, 7'd127},
    {64'h5555aaaa3333cccc, {64'h0000000000000001, 8'h01},       2'd2, 7'd127}
  };
  localparam logic [7:0] SAMP_SYN [7] = '{8'h07, 8'h0B, 8'h0D, 8'h0E, 8'h13, 8'h15, 8'h16};
  localparam int         SAMP_POS [7] = '{47, 37, 35, 39, 48, 30, 29};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_check = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_check;
  logic [1:0]  out_status;
  logic [6:0]  out_pos;
  logic        out_sticky;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_checker i_secded_checker (
    .clk, .rst_n, .in_valid, .in_first, .in_data, .in_check,
    .out_valid, .out_data, .out_check, .out_status, .out_pos, .out_sticky
  );

  // Bit-serial model of R1: rotate the row in a variable.
  function automatic logic [7:0] ref_check(input logic [63:0] d);
    logic [63:0] r = 64'h0000e8423c0f99ff;
    logic [7:0]  c;
    for (int i = 0; i < 8; i++) begin
      c[i] = ^(d & r);
      r = {r[55:0], r[63:56]};
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input logic [7:0] c, input logic first);
    @(negedge clk);
    in_valid = 1'b1; in_first = first; in_data = d; in_check = c;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [127:0] result();
    return {47'd0, out_valid, out_data, out_check, out_status, out_pos};
  endfunction

  function automatic logic [127:0] expect_res(input logic [63:0] d, input logic [7:0] c,
                                                input logic [1:0] st, input logic [6:0] p);
    return {47'd0, 1'b1, d, c, st, p};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [71:0] m;
    logic [7:0]  c;
    logic [1:0]  st;
    logic [6:0]  p;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 reset", {out_valid, out_sticky, out_data, out_check, out_status, out_pos},
          {1'b0, 1'b0, 64'd0, 8'd0, 2'd0, 7'd127});
    @(negedge clk); rst_n = 1'b1;

    // Vector table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      {d, m, st, p} = VEC[k];
      c = ref_check(d);
      drive(d ^ m[71:8], c ^ m[7:0], 1'b1);
      if (st == 2'd2) check("R5 table", result(), expect_res(d ^ m[71:8], c ^ m[7:0], st, p));
      else            check("R1 R2 R3 R4 table", result(), expect_res(d, c, st, p));
    end

    // R3 and R4: every single-bit flip of one pattern
    d = 64'ha5c3_0ff0_9e17_4b2d;
    c = ref_check(d);
    for (int b = 0; b < 72; b++) begin
      m = 72'd1 << b;
      p = (b >= 8) ? 7'(63 - (b - 8)) : 7'(64 + b);
      drive(d ^ m[71:8], c ^ m[7:0], 1'b1);
      check(b >= 8 ? "R4 single data flip" : "R3 single check flip",
            result(), expect_res(d, c, 2'd1, p));
    end

    // R5: double-bit flips pass through unmodified
    for (int b = 0; b < 59; b++) begin
      m = (72'd1 << b) | (72'd1 << (b + 13));
      drive(d ^ m[71:8], c ^ m[7:0], 1'b1);
      check("R5 double flip", result(), expect_res(d ^ m[71:8], c ^ m[7:0], 2'd2, 7'd127));
    end

    // R4 sample syndromes: zero data, check byte equals the syndrome
    for (int k = 0; k < 7; k++) begin
      drive(64'd0, SAMP_SYN[k], 1'b1);
      check("R4 sample syndrome", result(),
            expect_res(64'd1 << (63 - SAMP_POS[k]), SAMP_SYN[k], 2'd1, 7'(SAMP_POS[k])));
    end

    // R2 clean word with all-ones data
    drive(64'hffffffffffffffff, ref_check(64'hffffffffffffffff), 1'b1);
    check("R2 clean ones", result(),
          expect_res(64'hffffffffffffffff, ref_check(64'hffffffffffffffff), 2'd0, 7'd127));

    // R7 sticky flag across a transfer
    drive(64'd0, 8'h03, 1'b1);
    check("R7 sticky set", {127'd0, out_sticky}, 128'd1);
    drive(64'd0, 8'h00, 1'b0);
    check("R7 sticky kept", {127'd0, out_sticky}, 128'd1);
    drive(64'd0, 8'h01, 1'b0);
    check("R7 sticky kept on corrected", {127'd0, out_sticky}, 128'd1);
    drive(64'd0, 8'h00, 1'b1);
    check("R7 sticky restart", {127'd0, out_sticky}, 128'd0);
    drive(64'd0, 8'h05, 1'b1);
    check("R7 first word fatal", {127'd0, out_sticky}, 128'd1);

    // R6 hold: drop valid, change inputs
    drive(d, c ^ 8'h10, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_data = 64'h1234; in_check = 8'h77;
    @(posedge clk); #1;
    check("R6 hold", {out_valid, out_data, out_check, out_status, out_pos},
          {1'b0, d, c, 2'd1, 7'd68});
    @(posedge clk); #1;
    check("R6 hold second cycle", {out_valid, out_data, out_check, out_status, out_pos},
          {1'b0, d, c, 2'd1, 7'd68});

    finish_run();
  end
endmodule